// File: doc/BRIEF.md
# Pin-Group Scope Sampler

The block watches a bank of pin channels, each of which presents a 32-bit result value produced elsewhere, for example by an ADC filter. A configuration write selects one aligned group of four adjacent channels and turns sampling on or off. A read request then captures the least significant byte of each of the four selected channels on a single clock edge. It packs the four bytes into one 32-bit word and presents that word one clock later.

The configuration operand is a full 32-bit value, which may come from a register or from an immediate. Only its low seven bits are used. Bits 5:0 name a starting channel, and the two low bits of that number are forced to zero, so a group always begins on a multiple of four. Bit 6 is the enable. The block holds the word it returned until the next read request.

Top module: `scope_sampler`

## Requirements
- R1: After reset the block is disabled with group base 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A configuration write (`cfg_wr`=1) takes operand bits 6:0 only. Bits 31:7 have no effect on any later read.
- R3: The group base is operand bits 5:0 with bits 1:0 cleared. For example, operand 0x47 selects channels 4 to 7, and operand 0x7F selects channels 60 to 63.
- R4: An enabled read packs four consecutive channels starting at the base. Channel base+k supplies `rd_data` bits 8k+7:8k, for k = 0 to 3.
- R5: Only bits 7:0 of each selected channel reach the result. Bits 31:8 of the channels and all unselected channels have no effect.
- R6: When operand bit 6 was 0 at the last write, a read returns `rd_data` = 0 and still raises `rd_valid`.
- R7: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_req`=1, and 0 otherwise. The new `rd_data` appears in that same cycle.
- R8: All four channels are sampled at the clock edge where `rd_req` is high. Channel changes after that edge do not alter the returned word.
- R9: `rd_data` keeps its value in every cycle that follows a cycle without `rd_req`.
- R10: When `cfg_wr` and `rd_req` are high in the same cycle, the read uses the configuration that was in force before the write. The write takes effect for the next read.
- R11: Configuration stays unchanged in every cycle without `cfg_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Load configuration from `cfg_operand` |
| cfg_operand | input | 32 | Configuration value; bit 6 enables sampling, bits 5:0 give the start channel |
| ch_value | input | 2048 | 64 channel results of 32 bits each; channel n is at bits 32n+31:32n |
| rd_req | input | 1 | Capture the selected group this cycle |
| rd_data | output | 32 | Packed bytes from the last capture |
| rd_valid | output | 1 | `rd_data` was refreshed at the last edge |

## Verification
A configuration write and a read capture can happen in the same cycle. In that case the read must see the configuration from before the write. The bench provokes this by asserting both strobes together while changing the base, and by toggling the enable bit. The per-clock reference model applies its configuration update only after it has computed the read result. Any design that lets the new base or enable leak into that capture therefore produces a mismatch in the following cycle.

// File: rtl/scope_pkg.sv
// Shared definitions for the pin-group scope sampler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package scope_pkg;

    // Sampling state held by the configuration register.
    typedef enum logic {
        SCP_OFF = 1'b0,
        SCP_ON  = 1'b1
    } scp_mode_e;

endpackage

// File: rtl/scope_cfg_reg.sv
// Configuration register: captures the enable bit and the group-aligned base channel.
// Assumes LANES is a power of two no larger than 2**IDX_W; the enable sits just above the index bits.
module scope_cfg_reg
    import scope_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int LANES = 4,
    parameter int OP_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [OP_W-1:0]  operand,
    output scp_mode_e        mode,
    output logic [IDX_W-1:0] base
);

    localparam logic [IDX_W-1:0] ALIGN_MASK = ~IDX_W'(LANES - 1);
    localparam int               EN_BIT     = IDX_W;

    // Load the masked base and the enable on a write; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= SCP_OFF;
            base <= '0;
        end else if (wr) begin
            mode <= operand[EN_BIT] ? SCP_ON : SCP_OFF;
            base <= operand[IDX_W-1:0] & ALIGN_MASK;
        end
    end

endmodule

// File: rtl/scope_lane_mux.sv
// Lane selector: picks LANES adjacent channels from the flat bus and packs their low bytes.
// Assumes base is aligned to LANES, so base|k equals base+k and never leaves the bank.
module scope_lane_mux #(
    parameter int NUM_CH = 64,
    parameter int CH_W   = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int IDX_W  = 6
) (
    input  logic [NUM_CH*CH_W-1:0]  ch_flat,
    input  logic [IDX_W-1:0]        base,
    output logic [LANES*LANE_W-1:0] packed_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDX_W-1:0]  sel;
        logic [LANE_W-1:0] byte_q;

        // Form this lane's channel number from the aligned base.
        always_comb sel = base | IDX_W'(g);

        // Pull the low byte of the selected channel.
        always_comb begin
            byte_q = '0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (sel == IDX_W'(c)) byte_q = ch_flat[c*CH_W +: LANE_W];
            end
        end

        // Place the lane's byte; lower lanes occupy lower bits.
        always_comb packed_word[g*LANE_W +: LANE_W] = byte_q;
    end

endmodule

// File: rtl/scope_result_reg.sv
// Result register: captures the packed word (or zero when disabled) on a read request.
// Assumes the request is a single-cycle strobe; the word holds between requests.
module scope_result_reg
    import scope_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  scp_mode_e         mode,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out,
    output logic              valid
);

    // Sample the selected group, or zero, when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
        end else if (req) begin
            word_out <= (mode == SCP_ON) ? word_in : '0;
        end
    end

    // Flag the cycle that follows each request.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= req;
    end

endmodule

// File: rtl/scope_sampler.sv
// Pin-group scope sampler top: configuration register, lane selector and result register.
// Assumes LANES is a power of two dividing NUM_CH and that CH_W is at least LANE_W.
module scope_sampler
    import scope_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int CH_W   = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int OP_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [OP_W-1:0]            cfg_operand,
    input  logic [NUM_CH*CH_W-1:0]     ch_value,
    input  logic                       rd_req,
    output logic [LANES*LANE_W-1:0]    rd_data,
    output logic                       rd_valid
);

    localparam int IDX_W  = $clog2(NUM_CH);
    localparam int WORD_W = LANES * LANE_W;

    scp_mode_e         cfg_mode;
    logic [IDX_W-1:0]  cfg_base;
    logic [WORD_W-1:0] lane_word;

    scope_cfg_reg #(
        .IDX_W (IDX_W),
        .LANES (LANES),
        .OP_W  (OP_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .operand (cfg_operand),
        .mode    (cfg_mode),
        .base    (cfg_base)
    );

    scope_lane_mux #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W)
    ) u_mux (
        .ch_flat     (ch_value),
        .base        (cfg_base),
        .packed_word (lane_word)
    );

    scope_result_reg #(
        .WORD_W (WORD_W)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .mode     (cfg_mode),
        .word_in  (lane_word),
        .word_out (rd_data),
        .valid    (rd_valid)
    );

endmodule

// File: rtl/scope_sampler_chk.sv
// Property checker for scope_sampler, attached through bind.
// Assumes the parameters match the bound instance.
module scope_sampler_chk
    import scope_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int CH_W   = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int OP_W   = 32,
    parameter int IDX_W  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_wr,
    input logic [OP_W-1:0]         cfg_operand,
    input logic [NUM_CH*CH_W-1:0]  ch_value,
    input logic                    rd_req,
    input logic [LANES*LANE_W-1:0] rd_data,
    input logic                    rd_valid,
    input scp_mode_e               cfg_mode,
    input logic [IDX_W-1:0]        cfg_base
);

    localparam int ALIGN_BITS = $clog2(LANES);

    // R3
    base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_base[ALIGN_BITS-1:0] == '0);

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_mode == ($past(cfg_operand[IDX_W]) ? SCP_ON : SCP_OFF)));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(cfg_base) && $stable(cfg_mode)));

    // R7
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R6
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cfg_mode == SCP_OFF) |=> (rd_data == '0));

    // R4
    low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cfg_mode == SCP_ON) |=>
            (rd_data[LANE_W-1:0] == $past(ch_value[int'(cfg_base)*CH_W +: LANE_W])));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

endmodule

bind scope_sampler scope_sampler_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .OP_W   (OP_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_operand (cfg_operand),
    .ch_value    (ch_value),
    .rd_req      (rd_req),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .cfg_mode    (cfg_mode),
    .cfg_base    (cfg_base)
);

// File: tb/scope_sampler_tb.sv
`timescale 1ns/1ps
module scope_sampler_tb;

    localparam int NCH = 64;
    localparam int CW  = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_wr;
    logic [31:0]     cfg_operand;
    logic [NCH*CW-1:0] ch_value;
    logic            rd_req;
    logic [31:0]     rd_data;
    logic            rd_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural reference state
    bit          m_en;
    int          m_base;
    logic [31:0] m_data;
    bit          m_valid;

    scope_sampler u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_operand (cfg_operand),
        .ch_value    (ch_value),
        .rd_req      (rd_req),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < NCH; i++)
            ch_value[i*CW +: CW] = (32'(i) * 32'h0101_0101) ^ (32'(seed) * 32'h9E37_79B9);
    endtask

    // One clock: model the edge with pre-edge inputs, then compare both outputs.
    task automatic step(input string tag);
        logic [31:0] word;
        @(posedge clk);
        if (!rst_n) begin
            m_en = 0; m_base = 0; m_data = '0; m_valid = 0;
        end else begin
            m_valid = rd_req;
            if (rd_req) begin
                word = '0;
                if (m_en)
                    for (int k = 0; k < 4; k++)
                        word[k*8 +: 8] = ch_value[(m_base + k)*CW +: 8];
                m_data = word;
            end
            if (cfg_wr) begin
                m_en   = cfg_operand[6];
                m_base = int'(cfg_operand[5:0]) / 4 * 4;
            end
        end
        #1;
        check(rd_data === m_data, {tag, " data"}, rd_data, m_data);
        check(rd_valid === m_valid, {tag, " valid"}, 32'(rd_valid), 32'(m_valid));
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_wr = 0; rd_req = 0;
    endtask

    initial begin
        rst_n = 0; idle(); cfg_operand = '0; fill(1);
        m_en = 0; m_base = 0; m_data = '0; m_valid = 0;
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        // R1: read after reset is disabled, returns zero
        rd_req = 1; step("R1 R6 read after reset");
        idle(); step("R7 valid drops");

        // R4 R5: enable base 0
        cfg_wr = 1; cfg_operand = 32'h0000_0040; step("R2 write en base0");
        idle(); rd_req = 1; step("R4 base0 read");
        idle(); fill(7); step("R8 R9 hold after channel change");

        // R3: unaligned operand 0x47 -> channels 4..7
        cfg_wr = 1; cfg_operand = 32'h0000_0047; step("R3 write 0x47");
        idle(); rd_req = 1; step("R3 read group 4");
        fill(9); step("R5 back-to-back read new values");
        idle(); step("R9 hold");

        // R3: top group via 0x7F
        cfg_wr = 1; cfg_operand = 32'h0000_007F; step("R3 write 0x7F");
        idle(); rd_req = 1; step("R3 read group 60");
        idle(); step("R11 no write");

        // R2: upper bits set, low bits 0x48 -> channels 8..11 enabled
        cfg_wr = 1; cfg_operand = 32'hFFFF_FF80 | 32'h48; step("R2 upper bits ignored");
        idle(); rd_req = 1; step("R2 read group 8");
        // R2: upper bits set but bit 6 clear -> disabled
        cfg_wr = 1; cfg_operand = 32'hFFFF_FF88; rd_req = 0; step("R2 write disable");
        idle(); rd_req = 1; step("R6 disabled read zero");
        idle(); step("R9 hold zero");

        // R10: write and read together, read uses old config
        cfg_wr = 1; cfg_operand = 32'h0000_0054; rd_req = 1; step("R10 write+read old disabled");
        idle(); rd_req = 1; step("R10 next read new config");
        cfg_wr = 1; cfg_operand = 32'h0000_0020; rd_req = 1; step("R10 write disable+read old enabled");
        idle(); rd_req = 1; step("R10 R6 read after disable");

        // Multi-pattern sweep across groups
        for (int s = 0; s < 16; s++) begin
            cfg_wr = 1; cfg_operand = 32'h40 | 32'(s * 4 + (s % 4)); rd_req = (s % 2) == 1;
            step("R4 sweep write");
            idle(); fill(100 + s); rd_req = 1; step("R4 R5 sweep read");
            idle(); step("R9 sweep hold");
        end

        // R1: reset in the middle clears state
        rst_n = 0; step("R1 mid reset");
        rst_n = 1; rd_req = 1; step("R1 R6 after mid reset");
        idle(); step("R7 final idle");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule